// File: doc/BRIEF.md
# Multi-Input Wake-Up Debouncer

This block watches fourteen asynchronous wake-up pins from the slow clock domain. Each pin has its own enable bit and its own active level. A single programmable debounce length applies to every pin. When an enabled pin reaches its active level and holds it for that many slow-clock cycles, the block latches a sticky wake-up flag. At that same moment it records which enabled pins were active. The flag drives a level wake-up request, which stays high until software reads the status word. Reading the status word also clears it.

Pins 0 and 1 also feed a second, low-power debouncer. This debouncer counts pulses of a slower tick, supplied as a one-cycle enable on `lp_tick`, rather than counting slow-clock cycles. It has its own period code and its own per-pin enables. When it fires, it sets a per-pin status bit and can pulse `bkp_clear`, which lets a neighbouring block wipe its retained registers.

There are three registers: pin configuration, mode and status. They are reached through a plain write port and a plain read port with no handshake. Read data appears on `rd_data` one clock after `rd_en`. All other pins are simple control and status levels. Nothing in this block streams data, so there is no valid/ready back-pressure.

Top module: `wkup_debounce_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, and both `wake_req` and `bkp_clear` are low.
- R2: Address 0 holds the pin enables in bits 13:0 and the pin polarities in bits 29:16. Address 1 holds the low-power enables for pins 0 and 1 in bits 5 and 6, the clear enable in bit 7, the debounce code in bits 14:12 and the low-power code in bits 18:16. Unused bits read 0. `rd_data` carries the addressed word on the clock after `rd_en`.
- R3: A polarity bit of 1 makes high the active level, and 0 makes low the active level. A pin whose enable bit is 0 never triggers.
- R4: The debounce code selects N consecutive active slow-clock samples: code 0 gives 1, 1 gives 3, 2 gives 32, 3 gives 512, 4 gives 4096, and 5, 6 and 7 give 32768. After a pin changes, a two-stage synchronizer is followed by the count. The wake flag therefore sets on the (N+2)-th rising edge and not before.
- R5: If a pin leaves its active level before its count completes, its count restarts from zero.
- R6: A pin triggers once per active stretch. It must return to its inactive level before it can trigger again.
- R7: Status bit 1 is set by any pin trigger and stays set until address 2 is read. A trigger in the same cycle as the read survives the clear, and the read returns the value from before the read.
- R8: Status bits 29:16 record every pin that was enabled and at its active level during any trigger. These bits accumulate and clear on a status read.
- R9: `wake_req` is high whenever status bit 1, 13 or 14 is set, and it stays high until a status read clears them.
- R10: Low-power code 0 disables the low-power debouncer. Codes 1 to 7 require the pin to stay continuously active across code+1 tick pulses. Each pin is gated only by its mode bit (bit 5 for pin 0, bit 6 for pin 1) and uses its polarity bit. A firing sets status bit 13 for pin 0 or bit 14 for pin 1.
- R11: A low-power firing while mode bit 7 is set produces exactly one single-cycle `bkp_clear` pulse. With bit 7 clear, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 14 | Asynchronous wake-up pins |
| lp_tick | input | 1 | One-cycle enable marking a low-power tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| wake_req | output | 1 | Sticky wake-up request |
| bkp_clear | output | 1 | Pulse to clear retained registers |

## Verification
The bench checks the exact cycle count for every debounce code up to 32768 by sampling one edge before the expected edge and one edge after it. An off-by-one in the synchronizer or in the count compare shows up as an early or late flag. It checks short stretches broken by an inactive cycle, a pin held active after a clear, and a trigger that lands in the same cycle as a status read. A design that fails to restart counts would wake on broken stretches. One that re-triggers on a held level would re-raise `wake_req`. One that lets the clear win would lose an event. For the low-power path, the bench checks gating by the mode bits alone, the disable code, and suppression of the clear pulse. Random trials mix enables, polarities and active sets, which exposes swapped polarity or a snapshot taken from pins that were disabled.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  typedef enum logic [1:0] {
    REG_PINCFG = 2'd0,
    REG_MODE   = 2'd1,
    REG_STATUS = 2'd2
  } reg_sel_e;

  // Consecutive active slow-clock samples demanded by each debounce code.
  function automatic int unsigned dbc_need(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 3;
      3'd2:    return 32;
      3'd3:    return 512;
      3'd4:    return 4096;
      default: return 32768;
    endcase
  endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wkup_main_dbc.sv
module wkup_main_dbc #(
  parameter int NPINS = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] act_en,
  input  logic [CNT_W-1:0] need,
  output logic [NPINS-1:0] fire
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [CNT_W-1:0] cnt;

    // Fires on the sample that completes the run; saturation keeps it single-shot.
    assign fire[g] = act_en[g] && (cnt == need - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!act_en[g])     cnt <= '0;
      else if (cnt < need)     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wkup_lp_dbc.sv
module wkup_lp_dbc #(
  parameter int NLP  = 2,
  parameter int LP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            active,
  input  logic [NLP-1:0]  act_en,
  input  logic [LP_W-1:0] need,
  output logic [NLP-1:0]  fire
);
  for (genvar g = 0; g < NLP; g++) begin : g_lp
    logic [LP_W-1:0] cnt;

    assign fire[g] = active && act_en[g] && tick && (cnt == need - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!active || !act_en[g])   cnt <= '0;
      else if (tick && cnt < need)      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wkup_debounce_ctrl.sv
module wkup_debounce_ctrl
  import wkup_pkg::*;
#(
  parameter int NPINS  = 14,
  parameter int NLP    = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins,
  input  logic              lp_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_req,
  output logic              bkp_clear
);
  localparam int POL_LSB  = 16;
  localparam int SNAP_LSB = 16;
  localparam int LPS_LSB  = 13;
  localparam int WK_BIT   = 1;
  localparam int LPEN_LSB = 5;
  localparam int CLR_BIT  = 7;
  localparam int DBC_LSB  = 12;
  localparam int LPC_LSB  = 16;
  localparam int LP_W     = 4;

  logic [NPINS-1:0] pin_en, pin_pol, pins_s, act, act_en, fire, snap;
  logic [NLP-1:0]   lp_en, lp_flag, lp_fire;
  logic [2:0]       dbc_code, lp_code;
  logic             clr_en, wk_flag, any_fire, rd_status;
  logic [CNT_W-1:0] need;
  logic [LP_W-1:0]  lp_need;
  logic [DATA_W-1:0] rdv;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en   <= '0;
      pin_pol  <= '0;
      lp_en    <= '0;
      clr_en   <= 1'b0;
      dbc_code <= '0;
      lp_code  <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_PINCFG) begin
        pin_en  <= wr_data[NPINS-1:0];
        pin_pol <= wr_data[POL_LSB +: NPINS];
      end else if (wr_addr == REG_MODE) begin
        lp_en    <= wr_data[LPEN_LSB +: NLP];
        clr_en   <= wr_data[CLR_BIT];
        dbc_code <= wr_data[DBC_LSB +: 3];
        lp_code  <= wr_data[LPC_LSB +: 3];
      end
    end
  end

  wkup_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  assign act     = ~(pins_s ^ pin_pol);
  assign act_en  = act & pin_en;
  assign need    = CNT_W'(dbc_need(dbc_code));
  assign lp_need = LP_W'(lp_code) + LP_W'(1);

  wkup_main_dbc #(.NPINS(NPINS), .CNT_W(CNT_W)) u_main (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .need(need), .fire(fire)
  );

  wkup_lp_dbc #(.NLP(NLP), .LP_W(LP_W)) u_lp (
    .clk(clk), .rst_n(rst_n), .tick(lp_tick), .active(lp_code != 3'd0),
    .act_en(act[NLP-1:0] & lp_en), .need(lp_need), .fire(lp_fire)
  );

  assign any_fire  = |fire;
  assign rd_status = rd_en && (rd_addr == REG_STATUS);

  // Sticky status; a new event wins over a concurrent read clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_flag   <= 1'b0;
      snap      <= '0;
      lp_flag   <= '0;
      bkp_clear <= 1'b0;
    end else begin
      wk_flag   <= (wk_flag & ~rd_status) | any_fire;
      snap      <= (rd_status ? '0 : snap) | (any_fire ? act_en : '0);
      lp_flag   <= (rd_status ? '0 : lp_flag) | lp_fire;
      bkp_clear <= clr_en & (|lp_fire);
    end
  end

  always_comb begin
    rdv = '0;
    case (rd_addr)
      REG_PINCFG: begin
        rdv[NPINS-1:0]        = pin_en;
        rdv[POL_LSB +: NPINS] = pin_pol;
      end
      REG_MODE: begin
        rdv[LPEN_LSB +: NLP] = lp_en;
        rdv[CLR_BIT]         = clr_en;
        rdv[DBC_LSB +: 3]    = dbc_code;
        rdv[LPC_LSB +: 3]    = lp_code;
      end
      REG_STATUS: begin
        rdv[WK_BIT]            = wk_flag;
        rdv[LPS_LSB +: NLP]    = lp_flag;
        rdv[SNAP_LSB +: NPINS] = snap;
      end
      default: rdv = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rdv;
  end

  assign wake_req = wk_flag | (|lp_flag);

endmodule

// File: rtl/wkup_debounce_ctrl_chk.sv
module wkup_debounce_ctrl_chk #(
  parameter int NPINS = 14,
  parameter int NLP   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic             wake_req,
  input logic             bkp_clear,
  input logic             wk_flag,
  input logic [NLP-1:0]   lp_flag,
  input logic [NPINS-1:0] snap,
  input logic             any_fire,
  input logic             clr_en,
  input logic [NLP-1:0]   lp_en,
  input logic [2:0]       lp_code
);
  logic rd_status;
  assign rd_status = rd_en && (rd_addr == 2'd2);

  assert_wake_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !rd_status) |=> wake_req);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !any_fire) |=> !wk_flag);

  assert_flag_needs_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk_flag) |-> $past(any_fire));

  assert_snap_implies_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|snap) |-> wk_flag);

  assert_lp_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_flag[0]) |-> $past(lp_en[0] && lp_code != 3'd0));

  assert_clr_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_clear |-> $past(clr_en));
endmodule

bind wkup_debounce_ctrl wkup_debounce_ctrl_chk #(.NPINS(NPINS), .NLP(NLP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .wake_req(wake_req), .bkp_clear(bkp_clear), .wk_flag(wk_flag),
  .lp_flag(lp_flag), .snap(snap), .any_fire(any_fire), .clr_en(clr_en),
  .lp_en(lp_en), .lp_code(lp_code)
);

// File: tb/wkup_debounce_ctrl_test.sv
module wkup_debounce_ctrl_test;
  localparam int NP = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic        lp_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wake_req, bkp_clear;

  int checks = 0, fails = 0, clr_cnt = 0, tcnt = 0;
  bit tick_on = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  wkup_debounce_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .lp_tick(lp_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_req(wake_req), .bkp_clear(bkp_clear)
  );

  initial forever begin
    @(negedge clk);
    lp_tick = tick_on && (tcnt % 8 == 0);
    tcnt++;
  end

  always @(negedge clk) if (bkp_clear) clr_cnt++;

  function automatic int unsigned need_of(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input logic [NP-1:0] en, input logic [NP-1:0] pol);
    return {2'b00, pol, 2'b00, en};
  endfunction

  function automatic logic [31:0] mode_word(input logic [1:0] lpen, input logic clr,
                                             input logic [2:0] dbc, input logic [2:0] lpc);
    return (32'(lpen) << 5) | (32'(clr) << 7) | (32'(dbc) << 12) | (32'(lpc) << 16);
  endfunction

  function automatic logic [NP-1:0] drive(input logic [NP-1:0] a, input logic [NP-1:0] pol);
    return ~(a ^ pol);
  endfunction

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic setup(input logic [NP-1:0] en, input logic [NP-1:0] pol, input logic [31:0] mode);
    logic [31:0] junk;
    pins = drive('0, pol);
    wr(2'd0, cfg_word('0, pol));
    wr(2'd1, mode);
    step(4);
    wr(2'd0, cfg_word(en, pol));
    rd(2'd2, junk);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    chk("R1 wake", 32'(wake_req), 0);
    chk("R1 clear", 32'(bkp_clear), 0);
    rd(2'd0, d); chk("R1 cfg", d, 0);
    rd(2'd1, d); chk("R1 mode", d, 0);
    rd(2'd2, d); chk("R1 status", d, 0);

    // R2: field placement and readback
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 cfg", d, 32'h3FFF_3FFF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 mode", d, 32'h0007_70E0);
    wr(2'd1, 32'h0); wr(2'd0, 32'h0);

    // R3/R4/R8 random trials
    for (int t = 0; t < 24; t++) begin
      logic [NP-1:0] en, pol, a;
      int code;
      logic we;
      en = NP'($urandom); pol = NP'($urandom); a = NP'($urandom);
      code = $urandom % 3;
      setup(en, pol, mode_word(2'b00, 1'b0, 3'(code), 3'd0));
      pins = drive(a, pol);
      step(need_of(code) + 1);
      chk("R4 early", 32'(wake_req), 0);
      step(1);
      we = |(a & en);
      chk("R3 wake", 32'(wake_req), 32'(we));
      rd(2'd2, d);
      chk("R8 snapshot", d, {2'b00, a & en, 14'd0, we, 1'b0});
      rd(2'd2, d);
      chk("R7 cleared", d, 0);
      pins = drive('0, pol);
    end

    // R4: long codes, exact edge
    for (int c = 3; c <= 6; c++) begin
      setup(14'h0001, 14'h0001, mode_word(2'b00, 1'b0, 3'(c), 3'd0));
      pins = drive(14'h0001, 14'h0001);
      step(need_of(c) + 1);
      chk("R4 long early", 32'(wake_req), 0);
      step(1);
      chk("R4 long edge", 32'(wake_req), 1);
      rd(2'd2, d);
    end

    // R5: broken stretches restart the count (N=3)
    setup(14'h0010, 14'h0010, mode_word(2'b00, 1'b0, 3'd1, 3'd0));
    pins = 14'h0010; step(2); pins = 14'h0000; step(1);
    pins = 14'h0010; step(2); pins = 14'h0000; step(4);
    chk("R5 no wake on short runs", 32'(wake_req), 0);
    pins = 14'h0010; step(5);
    chk("R5 full run wakes", 32'(wake_req), 1);

    // R6: held pin fires once
    rd(2'd2, d);
    step(10);
    chk("R6 held no refire", 32'(wake_req), 0);
    rd(2'd2, d); chk("R6 status empty", d, 0);
    pins = 14'h0000; step(3);
    pins = 14'h0010; step(5);
    chk("R6 new stretch", 32'(wake_req), 1);
    rd(2'd2, d);
    pins = 14'h0000;

    // R7: trigger coincides with status read (N=1, flag sets on third edge)
    setup(14'h0100, 14'h0100, mode_word(2'b00, 1'b0, 3'd0, 3'd0));
    pins = 14'h0100;
    step(2);
    rd_en = 1'b1; rd_addr = 2'd2;
    @(negedge clk); rd_en = 1'b0;
    chk("R7 read sees old value", rd_data, 0);
    chk("R7 event survives clear", 32'(wake_req), 1);
    rd(2'd2, d); chk("R7 kept status", d, 32'h0100_0002);
    pins = 14'h0000;

    // R8: second pin active but not yet complete is captured
    setup(14'h002C, 14'h002C, mode_word(2'b00, 1'b0, 3'd1, 3'd0));
    pins = 14'h0004; step(1); pins = 14'h000C; step(8);
    rd(2'd2, d); chk("R8 partial pin captured", d, 32'h000C_0002);
    pins = 14'h0000;

    // R10/R11/R9: low-power path on pin 0, main enable off
    tick_on = 1'b1;
    setup(14'h0000, 14'h0003, mode_word(2'b01, 1'b1, 3'd0, 3'd2));
    clr_cnt = 0;
    pins = 14'h0001; step(48);
    chk("R9 wake from low-power", 32'(wake_req), 1);
    chk("R11 one clear pulse", 32'(clr_cnt), 1);
    rd(2'd2, d); chk("R10 pin0 status", d, 32'h0000_2000);
    chk("R9 wake drops after read", 32'(wake_req), 0);
    pins = 14'h0000; step(4);

    // R10: pin 1 not gated in (mode bit 6 clear)
    pins = 14'h0002; step(48);
    rd(2'd2, d); chk("R10 pin1 gated off", d, 0);
    pins = 14'h0000; step(4);

    // R10: pin 1 gated in, clear disabled -> R11 no pulse
    wr(2'd1, mode_word(2'b10, 1'b0, 3'd0, 3'd1));
    clr_cnt = 0;
    pins = 14'h0002; step(40);
    rd(2'd2, d); chk("R10 pin1 status", d, 32'h0000_4000);
    chk("R11 no pulse without enable", 32'(clr_cnt), 0);
    pins = 14'h0000; step(4);

    // R10: code 0 disables
    wr(2'd1, mode_word(2'b11, 1'b1, 3'd0, 3'd0));
    pins = 14'h0003; step(48);
    rd(2'd2, d); chk("R10 disabled code", d, 0);
    chk("R10 disabled wake", 32'(wake_req), 0);
    tick_on = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule